// File: doc/BRIEF.md
# Next Line and Way Predictor

This fetch-stage block tells the instruction fetch unit which instruction-cache line and which way of that set to read on the next cycle. It does not produce a branch target address. The predictions sit in a tagless, direct-mapped table that is kept apart from the cache. The table is indexed by low bits of the fetch address. Each entry holds a line index, a way number and a two-bit branch-kind code. The fetch logic uses the kind code to decide between the predicted line and the sequential path. Returns and indirect jumps are looked up through the same kind of entry as direct branches.

When a branch resolves, the back end sends an update. The update names the resolved line, the way, the branch kind and whether the branch was taken. Because the table has no tags, two fetch addresses that share index bits also share an entry. Aliasing is accepted by design.

Top module: `nlw_pred`

## Requirements
- R1: After reset every entry holds kind 00, so a lookup of any address returns `pr_kind` = 00 and `pr_use` = 0.
- R2: A lookup sampled with `lk_valid` high drives `pr_line`, `pr_way` and `pr_kind` from the entry selected by `lk_pc[9:2]` in the next cycle.
- R3: The table has no tag. Two addresses with equal bits [9:2] return the same entry contents.
- R4: Kind encoding is 00 none, 01 conditional, 10 unconditional/call, 11 return/indirect. `pr_use` is 1 for kinds 10 and 11, and 0 for kind 00. For kind 01, `pr_use` equals the `lk_taken_hint` that was sampled with the lookup.
- R5: An update sampled with `up_valid` high is written one cycle later. A lookup sampled in that following cycle returns the old contents, and a lookup one cycle after that returns the new contents.
- R6: An update with `up_taken` high writes line, way and kind. An update with `up_taken` low writes only the kind and leaves the stored line and way unchanged.
- R7: In the cycle after a clock edge where `lk_valid` was low, `pr_use` is 0 and `pr_kind` is 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_pc | input | PC_W | Current fetch address |
| lk_taken_hint | input | 1 | Direction hint for conditional entries |
| up_valid | input | 1 | Update request |
| up_pc | input | PC_W | Address of the resolved fetch block |
| up_line | input | LINE_W | Resolved next cache line index |
| up_way | input | WAY_W | Resolved next way |
| up_kind | input | 2 | Resolved branch kind |
| up_taken | input | 1 | Resolved branch was taken |
| pr_line | output | LINE_W | Predicted line index |
| pr_way | output | WAY_W | Predicted way |
| pr_kind | output | 2 | Predicted branch kind |
| pr_use | output | 1 | Fetch should follow the predicted line |

## Verification
The case hardest to reach from the ports is a lookup that arrives in the single cycle when a staged update is being written to the same index. That lookup must see the old entry, and the lookup right after it must see the new one. The bench issues an update and then presents the lookup on the very next clock, without an idle cycle in between. It repeats the lookup one cycle later. The not-taken update that keeps the old line and way is reached by writing a taken entry first. The same index is then overwritten with a not-taken conditional that carries different line and way values.

// File: rtl/nlw_pkg.sv
package nlw_pkg;

   typedef enum logic [1:0] {
      BK_NONE  = 2'b00,
      BK_COND  = 2'b01,
      BK_JUMP  = 2'b10,
      BK_INDIR = 2'b11
   } brkind_e;

   // whether fetch follows the stored line for a given kind
   function automatic logic kind_follows(input logic [1:0] kind,
                                         input logic       hint,
                                         input logic       cond_needs_hint);
      logic r;
      case (kind)
         BK_NONE:  r = 1'b0;
         BK_COND:  r = cond_needs_hint ? hint : 1'b1;
         default:  r = 1'b1;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/nlw_upd_stage.sv
module nlw_upd_stage #(
   parameter int PC_W   = 32,
   parameter int IDX_LO = 2,
   parameter int IDX_W  = 8,
   parameter int LINE_W = 6,
   parameter int WAY_W  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              up_valid,
   input  logic [PC_W-1:0]   up_pc,
   input  logic [LINE_W-1:0] up_line,
   input  logic [WAY_W-1:0]  up_way,
   input  logic [1:0]        up_kind,
   input  logic              up_taken,
   output logic              wr_vld,
   output logic              wr_full,
   output logic [IDX_W-1:0]  wr_idx,
   output logic [LINE_W-1:0] wr_line,
   output logic [WAY_W-1:0]  wr_way,
   output logic [1:0]        wr_kind
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_vld  <= 1'b0;
         wr_full <= 1'b0;
         wr_idx  <= '0;
         wr_line <= '0;
         wr_way  <= '0;
         wr_kind <= 2'b00;
      end else begin
         wr_vld <= up_valid;
         if (up_valid) begin
            wr_full <= up_taken;
            wr_idx  <= up_pc[IDX_LO +: IDX_W];
            wr_line <= up_line;
            wr_way  <= up_way;
            wr_kind <= up_kind;
         end
      end
   end

endmodule

// File: rtl/nlw_table.sv
module nlw_table #(
   parameter int IDX_W  = 8,
   parameter int LINE_W = 6,
   parameter int WAY_W  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_vld,
   input  logic              wr_full,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [LINE_W-1:0] wr_line,
   input  logic [WAY_W-1:0]  wr_way,
   input  logic [1:0]        wr_kind,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [LINE_W-1:0] rd_line,
   output logic [WAY_W-1:0]  rd_way,
   output logic [1:0]        rd_kind
);

   localparam int DEPTH = 1 << IDX_W;

   logic [LINE_W-1:0] line_q [DEPTH];
   logic [WAY_W-1:0]  way_q  [DEPTH];
   logic [1:0]        kind_q [DEPTH];

   for (genvar e = 0; e < DEPTH; e++) begin : g_ent
      logic hit;
      assign hit = wr_vld && (wr_idx == IDX_W'(e));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            line_q[e] <= '0;
            way_q[e]  <= '0;
            kind_q[e] <= nlw_pkg::BK_NONE;
         end else if (hit) begin
            kind_q[e] <= wr_kind;
            if (wr_full) begin
               line_q[e] <= wr_line;
               way_q[e]  <= wr_way;
            end
         end
      end
   end

   assign rd_line = line_q[rd_idx];
   assign rd_way  = way_q[rd_idx];
   assign rd_kind = kind_q[rd_idx];

endmodule

// File: rtl/nlw_select.sv
module nlw_select #(
   parameter int LINE_W          = 6,
   parameter int WAY_W           = 2,
   parameter bit COND_NEEDS_HINT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lk_valid,
   input  logic              lk_taken_hint,
   input  logic [LINE_W-1:0] rd_line,
   input  logic [WAY_W-1:0]  rd_way,
   input  logic [1:0]        rd_kind,
   output logic [LINE_W-1:0] pr_line,
   output logic [WAY_W-1:0]  pr_way,
   output logic [1:0]        pr_kind,
   output logic              pr_use
);

   logic follow;

   if (COND_NEEDS_HINT) begin : g_hinted
      assign follow = nlw_pkg::kind_follows(rd_kind, lk_taken_hint, 1'b1);
   end else begin : g_always
      assign follow = nlw_pkg::kind_follows(rd_kind, lk_taken_hint, 1'b0);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pr_line <= '0;
         pr_way  <= '0;
         pr_kind <= 2'b00;
         pr_use  <= 1'b0;
      end else if (lk_valid) begin
         pr_line <= rd_line;
         pr_way  <= rd_way;
         pr_kind <= rd_kind;
         pr_use  <= follow;
      end else begin
         pr_kind <= 2'b00;
         pr_use  <= 1'b0;
      end
   end

endmodule

// File: rtl/nlw_pred.sv
module nlw_pred #(
   parameter int PC_W            = 32,
   parameter int IDX_LO          = 2,
   parameter int IDX_W           = 8,
   parameter int LINE_W          = 6,
   parameter int WAY_W           = 2,
   parameter bit COND_NEEDS_HINT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lk_valid,
   input  logic [PC_W-1:0]   lk_pc,
   input  logic              lk_taken_hint,
   input  logic              up_valid,
   input  logic [PC_W-1:0]   up_pc,
   input  logic [LINE_W-1:0] up_line,
   input  logic [WAY_W-1:0]  up_way,
   input  logic [1:0]        up_kind,
   input  logic              up_taken,
   output logic [LINE_W-1:0] pr_line,
   output logic [WAY_W-1:0]  pr_way,
   output logic [1:0]        pr_kind,
   output logic              pr_use
);

   if (IDX_LO + IDX_W > PC_W) begin : g_bad_idx
      $error("nlw_pred: index field exceeds PC width");
   end
   if (IDX_W < 1 || IDX_W > 12) begin : g_bad_depth
      $error("nlw_pred: IDX_W out of range");
   end
   if (LINE_W < 1 || WAY_W < 1) begin : g_bad_field
      $error("nlw_pred: line and way widths must be positive");
   end

   logic              wr_vld, wr_full;
   logic [IDX_W-1:0]  wr_idx;
   logic [LINE_W-1:0] wr_line, rd_line;
   logic [WAY_W-1:0]  wr_way, rd_way;
   logic [1:0]        wr_kind, rd_kind;
   logic              unused_pc_bits;

   assign unused_pc_bits = ^{lk_pc, up_pc};

   nlw_upd_stage #(.PC_W(PC_W), .IDX_LO(IDX_LO), .IDX_W(IDX_W),
                   .LINE_W(LINE_W), .WAY_W(WAY_W)) u_upd (
      .clk(clk), .rst_n(rst_n), .up_valid(up_valid), .up_pc(up_pc),
      .up_line(up_line), .up_way(up_way), .up_kind(up_kind), .up_taken(up_taken),
      .wr_vld(wr_vld), .wr_full(wr_full), .wr_idx(wr_idx),
      .wr_line(wr_line), .wr_way(wr_way), .wr_kind(wr_kind));

   nlw_table #(.IDX_W(IDX_W), .LINE_W(LINE_W), .WAY_W(WAY_W)) u_tbl (
      .clk(clk), .rst_n(rst_n), .wr_vld(wr_vld), .wr_full(wr_full),
      .wr_idx(wr_idx), .wr_line(wr_line), .wr_way(wr_way), .wr_kind(wr_kind),
      .rd_idx(lk_pc[IDX_LO +: IDX_W]),
      .rd_line(rd_line), .rd_way(rd_way), .rd_kind(rd_kind));

   nlw_select #(.LINE_W(LINE_W), .WAY_W(WAY_W),
                .COND_NEEDS_HINT(COND_NEEDS_HINT)) u_sel (
      .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_taken_hint(lk_taken_hint),
      .rd_line(rd_line), .rd_way(rd_way), .rd_kind(rd_kind),
      .pr_line(pr_line), .pr_way(pr_way), .pr_kind(pr_kind), .pr_use(pr_use));

endmodule

// File: rtl/nlw_pred_chk.sv
module nlw_pred_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       lk_valid,
   input logic       lk_taken_hint,
   input logic [1:0] pr_kind,
   input logic       pr_use
);

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_valid |=> (!pr_use && pr_kind == 2'b00)); // R7

   AST_NONE_NO_USE: assert property (@(posedge clk) disable iff (!rst_n)
      (pr_kind == 2'b00) |-> !pr_use); // R4

   AST_JUMP_USE: assert property (@(posedge clk) disable iff (!rst_n)
      (pr_kind[1]) |-> pr_use); // R4

   AST_COND_NO_HINT: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_valid && !lk_taken_hint) |=> (pr_kind != 2'b01 || !pr_use)); // R4

   AST_COND_HINT: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_valid && lk_taken_hint) |=> (pr_kind != 2'b01 || pr_use)); // R4

endmodule

bind nlw_pred nlw_pred_chk u_chk (
   .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_taken_hint(lk_taken_hint),
   .pr_kind(pr_kind), .pr_use(pr_use));

// File: tb/nlw_pred_tb.sv
module nlw_pred_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        lk_valid = 1'b0;
   logic [31:0] lk_pc = '0;
   logic        lk_taken_hint = 1'b0;
   logic        up_valid = 1'b0;
   logic [31:0] up_pc = '0;
   logic [5:0]  up_line = '0;
   logic [1:0]  up_way = '0;
   logic [1:0]  up_kind = '0;
   logic        up_taken = 1'b0;
   logic [5:0]  pr_line;
   logic [1:0]  pr_way;
   logic [1:0]  pr_kind;
   logic        pr_use;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   nlw_pred u_dut (
      .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_pc(lk_pc),
      .lk_taken_hint(lk_taken_hint), .up_valid(up_valid), .up_pc(up_pc),
      .up_line(up_line), .up_way(up_way), .up_kind(up_kind), .up_taken(up_taken),
      .pr_line(pr_line), .pr_way(pr_way), .pr_kind(pr_kind), .pr_use(pr_use));

   task automatic check(input string req, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // all tasks start and end at a falling edge
   task automatic lookup(input logic [31:0] pc, input logic hint);
      lk_valid = 1'b1; lk_pc = pc; lk_taken_hint = hint;
      @(negedge clk);
      lk_valid = 1'b0; lk_taken_hint = 1'b0;
   endtask

   task automatic update(input logic [31:0] pc, input logic [5:0] ln,
                         input logic [1:0] wy, input logic [1:0] kd, input logic tk);
      up_valid = 1'b1; up_pc = pc; up_line = ln; up_way = wy; up_kind = kd; up_taken = tk;
      @(negedge clk);
      up_valid = 1'b0;
   endtask

   task automatic expect_pred(input string req, input int ln, input int wy,
                              input int kd, input int us);
      check({req, " line"}, pr_line, ln);
      check({req, " way"},  pr_way,  wy);
      check({req, " kind"}, pr_kind, kd);
      check({req, " use"},  pr_use,  us);
   endtask

   task automatic t_reset;
      lookup(32'h0000_0100, 1'b1);
      check("R1 kind", pr_kind, 0); check("R1 use", pr_use, 0);
      lookup(32'h0000_03FC, 1'b1);
      check("R1 kind", pr_kind, 0); check("R1 use", pr_use, 0);
   endtask

   task automatic t_write_timing;
      update(32'h0000_0040, 6'd5, 2'd2, 2'b10, 1'b1);
      lookup(32'h0000_0040, 1'b0);           // sampled at the write edge
      check("R5 old kind", pr_kind, 0);
      check("R5 old use", pr_use, 0);
      lookup(32'h0000_0040, 1'b0);
      expect_pred("R5/R2 new", 5, 2, 2, 1);
   endtask

   task automatic t_alias_and_index;
      lookup(32'h0000_0440, 1'b0);           // bits 9:2 equal to 0x40
      expect_pred("R3 alias", 5, 2, 2, 1);
      lookup(32'h0000_0044, 1'b1);           // neighbouring index
      check("R2 other idx kind", pr_kind, 0);
   endtask

   task automatic t_kinds;
      update(32'h0000_0080, 6'd9, 2'd1, 2'b01, 1'b1);
      update(32'h0000_0084, 6'd33, 2'd3, 2'b11, 1'b1);
      lookup(32'h0000_0080, 1'b0);
      expect_pred("R4 cond no hint", 9, 1, 1, 0);
      lookup(32'h0000_0080, 1'b1);
      expect_pred("R4 cond hint", 9, 1, 1, 1);
      lookup(32'h0000_0084, 1'b0);
      expect_pred("R4 indirect", 33, 3, 3, 1);
   endtask

   task automatic t_not_taken;
      update(32'h0000_0040, 6'd63, 2'd3, 2'b01, 1'b0);
      @(negedge clk);
      lookup(32'h0000_0040, 1'b1);
      expect_pred("R6 keep line/way", 5, 2, 1, 1);
   endtask

   task automatic t_idle;
      lookup(32'h0000_0084, 1'b1);
      check("R7 pre use", pr_use, 1);
      @(negedge clk);
      check("R7 idle use", pr_use, 0);
      check("R7 idle kind", pr_kind, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 reset use", pr_use, 0);
      t_reset();
      t_write_timing();
      t_alias_and_index();
      t_kinds();
      t_not_taken();
      t_idle();
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         n_run++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

endmodule